// File: doc/BRIEF.md
# Half-Word Write-Masked GPIO Register Bank

This block holds the control registers of a 32-bit general-purpose I/O port and gives software a way to change any single bit without first reading the register back. Each 32-bit control register occupies two bus words 4 bytes apart. The lower word carries bits 15:0 and the upper word carries bits 31:16. In every write, the upper 16 data bits act as a per-bit enable for the lower 16 data bits. A register bit changes only where its enable is 1, and it takes the value of the matching data bit.

The bank holds seven such registers: the pin output levels, the pin directions, and five interrupt-setup registers (enable, mask, type, polarity and both-edge). Their current values leave the block on dedicated output ports for use by the pin and interrupt logic. A fixed read-only word at 0x78 identifies the hardware revision. The bus side is a plain valid/write/address/data request. Read data is registered and appears on the cycle after the read request.

Top module: `hmrb_top`

## Requirements
- R1: A write to the lower word of a register (byte offset base+0) sets register bit i (i = 0..15) to write-data bit i wherever write-data bit i+16 is 1, and leaves every other bit of that register unchanged.
- R2: A write to the upper word (base+4) does the same for register bits 16..31: bit 16+i takes write-data bit i wherever write-data bit i+16 is 1, and every other bit is unchanged.
- R3: A read of a lower word returns register bits 15:0 in read-data bits 15:0, with read-data bits 31:16 equal to 0.
- R4: A read of an upper word returns register bits 31:16 in read-data bits 15:0, with read-data bits 31:16 equal to 0.
- R5: Register bases are 0x00 output level (gpio_out_o), 0x08 direction with 1 meaning output (gpio_dir_o), 0x10 interrupt enable, 0x18 interrupt mask, 0x20 interrupt type, 0x28 interrupt polarity and 0x30 both-edge. Each register drives its own output port and nothing else.
- R6: A read at 0x78 returns 0x01000C2B. A write to 0x78 changes no register.
- R7: Writes to any other offset change no register. This covers 0x38 to 0x74, 0x7C, and any address whose two low bits are not 00. Reads of those offsets return 0.
- R8: While rst_ni is low, every register is 0 and rd_data_o is 0.
- R9: rd_data_o takes the read result on the clock edge that accepts the read request. It holds its value through write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Bits 31:16 are the enables, bits 15:0 the data |
| rd_data_o | output | 32 | Registered read data |
| gpio_out_o | output | 32 | Pin output levels |
| gpio_dir_o | output | 32 | Pin directions, 1 = output |
| irq_en_o | output | 32 | Interrupt enable |
| irq_mask_o | output | 32 | Interrupt mask |
| irq_type_o | output | 32 | Interrupt type |
| irq_pol_o | output | 32 | Interrupt polarity |
| irq_both_o | output | 32 | Both-edge select |

## Verification
Random writes use uncorrelated data and enable halves, so they show whether the enable really gates each bit and whether the data half supplies the new value. Directed single-bit set and clear writes, all-enable writes and all-zero-enable writes cover the extremes of the mask. A distinct pattern is written to each of the seven registers and checked on every output port, which exposes a wrong base offset or a crossed half. Reads of the version word, of the unused offsets and of misaligned addresses, plus writes to those same places, confirm that they return the values stated above and leave every register untouched.

// File: rtl/hmrb_pkg.sv
package hmrb_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned HALF_W     = DATA_W / 2;
  localparam int unsigned NUM_REGS   = 7;
  localparam logic [31:0] VERSION_ID = 32'h01000C2B;
  localparam int unsigned VER_OFFSET = 32'h78;
  localparam int unsigned REG_OUT  = 0;
  localparam int unsigned REG_DIR  = 1;
  localparam int unsigned REG_IEN  = 2;
  localparam int unsigned REG_IMSK = 3;
  localparam int unsigned REG_ITYP = 4;
  localparam int unsigned REG_IPOL = 5;
  localparam int unsigned REG_IBTH = 6;
endpackage

// File: rtl/hmrb_half_reg.sv
module hmrb_half_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] bit_en_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (q_o & ~bit_en_i) | (data_i & bit_en_i);
  end
endmodule

// File: rtl/hmrb_decode.sv
module hmrb_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned VER_OFF  = 32'h78
) (
  input  logic                valid_i,
  input  logic                write_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] wr_lo_o,
  output logic [NUM_REGS-1:0] wr_hi_o,
  output logic [NUM_REGS-1:0] rd_sel_o,
  output logic                rd_hi_o,
  output logic                rd_ver_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign idx      = addr_i[ADDR_W-1:3];
  assign rd_hi_o  = addr_i[2];
  assign rd_ver_o = (addr_i == ADDR_W'(VER_OFF));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    logic hit;
    assign hit         = aligned && (idx == IDX_W'(g));
    assign rd_sel_o[g] = hit;
    assign wr_lo_o[g]  = valid_i && write_i && hit && !addr_i[2];
    assign wr_hi_o[g]  = valid_i && write_i && hit &&  addr_i[2];
  end
endmodule

// File: rtl/hmrb_rdmux.sv
module hmrb_rdmux #(
  parameter int unsigned NUM_REGS = 7,
  parameter logic [31:0] VERSION  = 32'h0
) (
  input  logic [NUM_REGS-1:0][31:0] regs_i,
  input  logic [NUM_REGS-1:0]       sel_i,
  input  logic                      hi_i,
  input  logic                      ver_i,
  output logic [31:0]               word_o
);
  logic [31:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel_i[i]) picked = regs_i[i];
  end

  always_comb begin
    if (ver_i)      word_o = VERSION;
    else if (hi_i)  word_o = {16'h0, picked[31:16]};
    else            word_o = {16'h0, picked[15:0]};
  end
endmodule

// File: rtl/hmrb_top.sv
module hmrb_top
  import hmrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rd_data_o,
  output logic [31:0]       gpio_out_o,
  output logic [31:0]       gpio_dir_o,
  output logic [31:0]       irq_en_o,
  output logic [31:0]       irq_mask_o,
  output logic [31:0]       irq_type_o,
  output logic [31:0]       irq_pol_o,
  output logic [31:0]       irq_both_o
);
  logic [NUM_REGS-1:0]        wr_lo, wr_hi, rd_sel;
  logic                       rd_hi, rd_ver;
  logic [NUM_REGS-1:0][31:0]  reg_q;
  logic [31:0]                rd_word;

  hmrb_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .VER_OFF(VER_OFFSET)
  ) dec_i (
    .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .rd_sel_o(rd_sel),
    .rd_hi_o(rd_hi), .rd_ver_o(rd_ver)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    hmrb_half_reg #(.W(HALF_W)) lo_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_lo[g]),
      .data_i(req_wdata_i[HALF_W-1:0]), .bit_en_i(req_wdata_i[DATA_W-1:HALF_W]),
      .q_o(reg_q[g][HALF_W-1:0])
    );
    hmrb_half_reg #(.W(HALF_W)) hi_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_hi[g]),
      .data_i(req_wdata_i[HALF_W-1:0]), .bit_en_i(req_wdata_i[DATA_W-1:HALF_W]),
      .q_o(reg_q[g][DATA_W-1:HALF_W])
    );
  end

  hmrb_rdmux #(.NUM_REGS(NUM_REGS), .VERSION(VERSION_ID)) mux_i (
    .regs_i(reg_q), .sel_i(rd_sel), .hi_i(rd_hi), .ver_i(rd_ver), .word_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rd_data_o <= '0;
    else if (req_valid_i && !req_write_i) rd_data_o <= rd_word;
  end

  assign gpio_out_o = reg_q[REG_OUT];
  assign gpio_dir_o = reg_q[REG_DIR];
  assign irq_en_o   = reg_q[REG_IEN];
  assign irq_mask_o = reg_q[REG_IMSK];
  assign irq_type_o = reg_q[REG_ITYP];
  assign irq_pol_o  = reg_q[REG_IPOL];
  assign irq_both_o = reg_q[REG_IBTH];
endmodule

// File: rtl/hmrb_checker.sv
module hmrb_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic [31:0]       rd_data_o,
  input logic [31:0]       gpio_out_o,
  input logic [31:0]       gpio_dir_o,
  input logic [31:0]       irq_en_o,
  input logic [31:0]       irq_mask_o,
  input logic [31:0]       irq_type_o,
  input logic [31:0]       irq_pol_o,
  input logic [31:0]       irq_both_o
);
  logic wr_any, rd_any, unmapped;
  assign wr_any   = req_valid_i && req_write_i;
  assign rd_any   = req_valid_i && !req_write_i;
  assign unmapped = (req_addr_i[1:0] != 2'b00) || (req_addr_i >= ADDR_W'(8'h38));

  AST_OUT_LO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any && req_addr_i == ADDR_W'(0) |=> gpio_out_o[15:0] ==
      (($past(req_wdata_i[15:0]) & $past(req_wdata_i[31:16])) |
       ($past(gpio_out_o[15:0]) & ~$past(req_wdata_i[31:16])))); // R1

  AST_DIR_HI_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any && req_addr_i == ADDR_W'(8'h0C) |=> gpio_dir_o[31:16] ==
      (($past(req_wdata_i[15:0]) & $past(req_wdata_i[31:16])) |
       ($past(gpio_dir_o[31:16]) & ~$past(req_wdata_i[31:16])))); // R2

  AST_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any && req_addr_i != ADDR_W'(8'h78) |=> rd_data_o[31:16] == 16'h0); // R3

  AST_VERSION_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any && req_addr_i == ADDR_W'(8'h78) |=> rd_data_o == 32'h01000C2B); // R6

  AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any && unmapped |=> $stable(gpio_out_o) && $stable(gpio_dir_o) &&
      $stable(irq_en_o) && $stable(irq_mask_o) && $stable(irq_type_o) &&
      $stable(irq_pol_o) && $stable(irq_both_o)); // R7

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (gpio_out_o | gpio_dir_o | irq_en_o | irq_mask_o |
      irq_type_o | irq_pol_o | irq_both_o | rd_data_o) == 32'h0); // R8

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_any |=> $stable(rd_data_o)); // R9
endmodule

bind hmrb_top hmrb_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
  .rd_data_o(rd_data_o), .gpio_out_o(gpio_out_o), .gpio_dir_o(gpio_dir_o),
  .irq_en_o(irq_en_o), .irq_mask_o(irq_mask_o), .irq_type_o(irq_type_o),
  .irq_pol_o(irq_pol_o), .irq_both_o(irq_both_o)
);

// File: tb/hmrb_top_tb_top.sv
module hmrb_top_tb_top;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREG   = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [31:0]       req_wdata_i = '0;
  logic [31:0]       rd_data_o, gpio_out_o, gpio_dir_o, irq_en_o, irq_mask_o;
  logic [31:0]       irq_type_o, irq_pol_o, irq_both_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [31:0] mdl [NREG];
  logic [31:0] last_rd = '0;

  always #10 clk_i = ~clk_i;

  hmrb_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_data_o(rd_data_o), .gpio_out_o(gpio_out_o), .gpio_dir_o(gpio_dir_o),
    .irq_en_o(irq_en_o), .irq_mask_o(irq_mask_o), .irq_type_o(irq_type_o),
    .irq_pol_o(irq_pol_o), .irq_both_o(irq_both_o)
  );

  function automatic logic [31:0] port_val(int idx);
    case (idx)
      0: return gpio_out_o;
      1: return gpio_dir_o;
      2: return irq_en_o;
      3: return irq_mask_o;
      4: return irq_type_o;
      5: return irq_pol_o;
      default: return irq_both_o;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a);
    int idx;
    if (a == 8'h78) return 32'h01000C2B;
    if (a[1:0] != 2'b00) return 32'h0;
    idx = int'(a >> 3);
    if (idx >= NREG) return 32'h0;
    return a[2] ? {16'h0, mdl[idx][31:16]} : {16'h0, mdl[idx][15:0]};
  endfunction

  function automatic void model_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    int idx;
    logic [15:0] nv;
    if (a[1:0] != 2'b00) return;
    idx = int'(a >> 3);
    if (idx >= NREG) return;
    if (a[2]) begin
      nv = (mdl[idx][31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
      mdl[idx][31:16] = nv;
    end else begin
      nv = (mdl[idx][15:0] & ~d[31:16]) | (d[15:0] & d[31:16]);
      mdl[idx][15:0] = nv;
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    for (int i = 0; i < NREG; i++)
      check(port_val(i) === mdl[i], req, port_val(i), mdl[i]);
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input string req);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
    model_write(a, d);
    check_ports(req);
    check(rd_data_o === last_rd, "R9 hold on write", rd_data_o, last_rd);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rd_data_o === e, req, rd_data_o, e);
    last_rd = e;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    check_ports("R8 reset");
    check(rd_data_o === 32'h0, "R8 reset rd", rd_data_o, 32'h0);
    rst_ni = 1'b1;

    // R5: distinct pattern per register
    for (int i = 0; i < NREG; i++) begin
      do_write(ADDR_W'(i * 8),     32'hFFFF_0000 | (32'h1100 + i), "R5 lo");
      do_write(ADDR_W'(i * 8 + 4), 32'hFFFF_0000 | (32'hA050 + i), "R5 hi");
    end
    for (int i = 0; i < NREG; i++) begin
      do_read(ADDR_W'(i * 8),     "R3 lo read");
      do_read(ADDR_W'(i * 8 + 4), "R4 hi read");
    end

    // R1/R2 single-bit set and clear
    do_write(8'h00, 32'h0004_0004, "R1 set bit2");
    do_write(8'h00, 32'h0100_0000, "R1 clear bit8");
    do_write(8'h0C, 32'h8000_8000, "R2 set bit31");
    do_write(8'h0C, 32'h0001_0000, "R2 clear bit16");
    do_write(8'h10, 32'h0000_FFFF, "R1 zero enable no change");
    do_write(8'h2C, 32'hFFFF_FFFF, "R2 all enable");
    do_read(8'h2C, "R4 all ones read");

    // R6, R7
    do_read(8'h78, "R6 version");
    do_write(8'h78, 32'hFFFF_FFFF, "R6 write ignored");
    do_write(8'h7C, 32'hFFFF_FFFF, "R7 write 0x7C ignored");
    do_write(8'h38, 32'hFFFF_FFFF, "R7 write 0x38 ignored");
    do_write(8'h01, 32'hFFFF_FFFF, "R7 misaligned write ignored");
    do_read(8'h7C, "R7 read 0x7C");
    do_read(8'h40, "R7 read 0x40");
    do_read(8'h02, "R7 misaligned read");

    // random mix
    for (int n = 0; n < 400; n++) begin
      a = ADDR_W'($urandom() % 128);
      if (($urandom() % 4) != 0) a[1:0] = 2'b00;
      d = $urandom();
      if (($urandom() % 2) == 0) do_write(a, d, "R1 R2 R7 random write");
      else                       do_read(a, "R3 R4 R6 R7 random read");
    end

    // R9: idle holds read data
    repeat (3) @(negedge clk_i);
    check(rd_data_o === last_rd, "R9 hold idle", rd_data_o, last_rd);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule